// File: doc/BRIEF.md
# Exponential ADC Code Mapper

This block turns a 10-bit converter code into a 16-bit value that grows roughly as two raised to the power code/64. The result gives fine steps at the low end of the code range and coarse steps at the high end, which suits a control loop whose gain should scale with its operating point. The four high code bits select a power-of-two segment. The six low bits place the result inside that segment.

The placement inside a segment is done in one of two ways, chosen per sample. Interpolation mode adds a straight-line step to the segment floor, built from shifts and one narrow multiply. A programmable split of six shift positions trades resolution on the segment slope against resolution on the offset. Table mode reads a 64-entry table of fractional powers of two, scaled so that entry 0 is 32768, and shifts the entry right by fifteen minus the segment number. This gives the accuracy of a full 1024-entry table at one sixteenth of the storage.

Samples enter with a valid strobe and leave on a valid strobe exactly two clocks later. Every cycle can carry a new sample, and the mode and shift split travel with each sample through the pipeline.

Top module: `adc_exp_mapper`

## Requirements
- R1: After a synchronous reset, out_valid is 0 and out_result is 0.
- R2: out_valid equals the in_valid value sampled two rising edges earlier, so a full-rate stream is accepted without gaps.
- R3: With in_mode = 0 (interpolate), out_result = 2^e + (2^e >> r) * (f >> (6 - r)), where e = in_code[9:6], f = in_code[5:0] and r = in_rise_shift.
- R4: An in_rise_shift value of 7 gives exactly the result of 6.
- R5: With in_mode = 1 (table), out_result = T[f] >> (15 - e), where T[k] = round(32768 * 2^(k/64)).
- R6: A code whose low six bits are zero yields exactly 2^e in both modes, and no result falls below 2^e for its segment.
- R7: Results are limited to 65535. In interpolation mode the step added inside a segment is always less than the segment floor, so the largest code gives 65024 at r = 6.
- R8: While no sample completes, out_result holds the last completed result.
- R9: in_mode and in_rise_shift are taken in the same cycle as in_code. Changing them on each cycle of a stream affects only the sample that enters with them.
- R10: For a fixed mode and shift split, results never decrease as the code increases, and a result below segment 15 stays below 2^(e+1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A sample is presented this cycle |
| in_mode | input | 1 | 0 = linear interpolation, 1 = fractional table |
| in_rise_shift | input | 3 | Right shift applied to the segment span in interpolation mode (0..6, 7 acts as 6) |
| in_code | input | 10 | Converter code |
| out_valid | output | 1 | out_result carries a new value this cycle |
| out_result | output | 16 | Mapped exponential value |

## Verification
Any wrong stored value shows up at out_result exactly two cycles after the sample that carried it. No state outlives a sample except the held output, so one bad segment number, table entry or shift split corrupts only that one result. A stale or mis-sampled configuration bit appears as a result that matches the neighbouring sample's mode or shift instead of its own. Alternating the configuration on every cycle exposes this at once. A fault in the pipeline valid bits shows as a strobe that lands one cycle early or late, or as a held value that changes during idle cycles.

// File: rtl/adc_exp_pkg.sv
package adc_exp_pkg;

    localparam int CODE_W  = 10;
    localparam int OUT_W   = 16;
    localparam int FRAC_W  = 6;
    localparam int SEG_W   = CODE_W - FRAC_W;
    localparam int SEG_N   = 1 << SEG_W;
    localparam int TBL_N   = 1 << FRAC_W;
    localparam int SH_W    = $clog2(FRAC_W + 1);
    localparam int PROD_W  = OUT_W + FRAC_W;
    localparam int SUM_W   = PROD_W + 1;
    localparam logic [OUT_W-1:0] OUT_MAX = '1;

    typedef enum logic {
        MAP_INTERP = 1'b0,
        MAP_TABLE  = 1'b1
    } map_mode_e;

    typedef struct packed {
        map_mode_e               mode;
        logic [SEG_W-1:0]        seg;
        logic [OUT_W-1:0]        base;
        logic [PROD_W-1:0]       prod;
        logic [OUT_W-1:0]        entry;
    } prep_t;

    // Fractional power of two, fixed point with the top output bit as 1.0
    function automatic logic [OUT_W-1:0] frac_pow2(input int k);
        real scale;
        real v;
        scale = real'(longint'(1) << (OUT_W - 1));
        v = scale * (2.0 ** (real'(k) / real'(TBL_N)));
        return OUT_W'($rtoi(v + 0.5));
    endfunction

    // Shift split clamp: values beyond the fraction width act as the width
    function automatic logic [SH_W-1:0] clamp_shift(input logic [SH_W-1:0] s);
        return (int'(s) > FRAC_W) ? SH_W'(FRAC_W) : s;
    endfunction

endpackage

// File: rtl/adc_exp_frac_rom.sv
module adc_exp_frac_rom
    import adc_exp_pkg::*;
(
    input  logic [FRAC_W-1:0] idx,
    output logic [OUT_W-1:0]  value
);

    logic [OUT_W-1:0] rom [TBL_N];

    for (genvar k = 0; k < TBL_N; k++) begin : g_entry
        assign rom[k] = frac_pow2(k);
    end

    assign value = rom[idx];

endmodule

// File: rtl/adc_exp_prep.sv
module adc_exp_prep
    import adc_exp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              i_valid,
    input  map_mode_e         i_mode,
    input  logic [SH_W-1:0]   i_rise_sh,
    input  logic [CODE_W-1:0] i_code,
    output logic              o_valid,
    output prep_t             o_stage
);

    logic [SEG_W-1:0]  seg;
    logic [FRAC_W-1:0] off;
    logic [SH_W-1:0]   rs_eff;
    logic [SH_W-1:0]   os_eff;
    logic [OUT_W-1:0]  base;
    logic [OUT_W-1:0]  rise;
    logic [PROD_W-1:0] prod;
    logic [OUT_W-1:0]  entry;
    prep_t             nxt;

    assign seg    = i_code[CODE_W-1:FRAC_W];
    assign off    = i_code[FRAC_W-1:0];
    assign rs_eff = clamp_shift(i_rise_sh);
    assign os_eff = SH_W'(FRAC_W) - rs_eff;

    adc_exp_frac_rom u_rom (
        .idx   (off),
        .value (entry)
    );

    always_comb begin
        base = OUT_W'(1) << seg;
        // Span of a segment: next power of two minus this one, equal to base
        rise = base;
        prod = PROD_W'(rise >> rs_eff) * PROD_W'(off >> os_eff);
        nxt.mode  = i_mode;
        nxt.seg   = seg;
        nxt.base  = base;
        nxt.prod  = prod;
        nxt.entry = entry;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            o_valid <= 1'b0;
            o_stage <= '0;
        end else begin
            o_valid <= i_valid;
            if (i_valid) begin
                o_stage <= nxt;
            end
        end
    end

    // In-segment step stays below the segment floor
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
        (o_valid && o_stage.mode == MAP_INTERP) |-> (o_stage.prod < PROD_W'(o_stage.base)));

    // Table entry lies within one octave above the scale point
    assert_entry_octave_R5: assert property (@(posedge clk) disable iff (rst)
        (o_valid && o_stage.mode == MAP_TABLE) |-> o_stage.entry[OUT_W-1]);

endmodule

// File: rtl/adc_exp_finish.sv
module adc_exp_finish
    import adc_exp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             i_valid,
    input  prep_t            i_stage,
    output logic             o_valid,
    output logic [OUT_W-1:0] o_data
);

    logic [SEG_W-1:0] shift;
    logic [OUT_W-1:0] tbl_val;
    logic [SUM_W-1:0] sum;
    logic [OUT_W-1:0] lin_val;
    logic [OUT_W-1:0] res;

    always_comb begin
        shift   = SEG_W'(SEG_N - 1) - i_stage.seg;
        tbl_val = i_stage.entry >> shift;
        sum     = SUM_W'(i_stage.base) + SUM_W'(i_stage.prod);
        lin_val = (sum > SUM_W'(OUT_MAX)) ? OUT_MAX : sum[OUT_W-1:0];
        res     = (i_stage.mode == MAP_TABLE) ? tbl_val : lin_val;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            o_valid <= 1'b0;
            o_data  <= '0;
        end else begin
            o_valid <= i_valid;
            if (i_valid) begin
                o_data <= res;
            end
        end
    end

    assert_seg_floor_R6: assert property (@(posedge clk) disable iff (rst)
        i_valid |=> ({1'b0, o_data} >= ((OUT_W+1)'(1) << $past(i_stage.seg))));

    assert_seg_ceiling_R10: assert property (@(posedge clk) disable iff (rst)
        (i_valid && i_stage.seg != SEG_W'(SEG_N - 1))
        |=> ({1'b0, o_data} < ((OUT_W+1)'(2) << $past(i_stage.seg))));

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !i_valid |=> $stable(o_data));

endmodule

// File: rtl/adc_exp_mapper.sv
module adc_exp_mapper
    import adc_exp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_mode,
    input  logic [SH_W-1:0]   in_rise_shift,
    input  logic [CODE_W-1:0] in_code,
    output logic              out_valid,
    output logic [OUT_W-1:0]  out_result
);

    logic  mid_valid;
    prep_t mid_stage;

    adc_exp_prep u_prep (
        .clk       (clk),
        .rst       (rst),
        .i_valid   (in_valid),
        .i_mode    (map_mode_e'(in_mode)),
        .i_rise_sh (in_rise_shift),
        .i_code    (in_code),
        .o_valid   (mid_valid),
        .o_stage   (mid_stage)
    );

    adc_exp_finish u_finish (
        .clk     (clk),
        .rst     (rst),
        .i_valid (mid_valid),
        .i_stage (mid_stage),
        .o_valid (out_valid),
        .o_data  (out_result)
    );

    // Cycles since reset, saturating at two, so the latency check never
    // looks back past the reset
    logic [1:0] warm;
    always_ff @(posedge clk) begin
        if (rst) begin
            warm <= '0;
        end else if (warm != 2'd2) begin
            warm <= warm + 2'd1;
        end
    end

    assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd2) |-> (out_valid == $past(in_valid, 2)));

    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && out_result == '0));

endmodule

// File: tb/adc_exp_mapper_bench.sv
module adc_exp_mapper_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        in_mode;
    logic [2:0]  in_rise_shift;
    logic [9:0]  in_code;
    logic        out_valid;
    logic [15:0] out_result;

    always #2.5 clk = ~clk;

    adc_exp_mapper u_adc_exp_mapper (
        .clk           (clk),
        .rst           (rst),
        .in_valid      (in_valid),
        .in_mode       (in_mode),
        .in_rise_shift (in_rise_shift),
        .in_code       (in_code),
        .out_valid     (out_valid),
        .out_result    (out_result)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // Two-deep model of the pipeline, built from the requirements
    bit    v_d1 = 0, v_d2 = 0;
    int    e_d1 = 0, e_d2 = 0;
    string t_d1 = "", t_d2 = "";
    bit    m_d1 = 0, m_d2 = 0;
    int    c_d1 = 0, c_d2 = 0;
    int    last_out = 0;
    int    prev_out = 0;
    bit    mono_on  = 0;

    function automatic int model_interp(int code, int rs);
        int e, f, r, base, v;
        e = code / 64;
        f = code % 64;
        r = (rs > 6) ? 6 : rs;
        base = 1 << e;
        v = base + (base >> r) * (f >> (6 - r));
        return (v > 65535) ? 65535 : v;
    endfunction

    function automatic int model_table(int code);
        int e, k, t;
        e = code / 64;
        k = code % 64;
        t = $rtoi(32768.0 * (2.0 ** (real'(k) / 64.0)) + 0.5);
        return t >> (15 - e);
    endfunction

    task automatic report(bit ok, string req, int act, int expv, string what);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic step(bit v, bit mode, int rs, int code, string tag);
        int expv;
        @(negedge clk);
        report(out_valid == v_d2, "R2", int'(out_valid), int'(v_d2), "valid timing");
        if (v_d2) begin
            report(int'(out_result) == e_d2, t_d2, int'(out_result), e_d2, "result");
            if (mono_on && m_d2 && c_d2 != 0)
                report(int'(out_result) >= prev_out, "R10", int'(out_result), prev_out, "monotonic");
            prev_out = int'(out_result);
            last_out = e_d2;
        end else begin
            report(int'(out_result) == last_out, "R8", int'(out_result), last_out, "idle hold");
        end
        expv = mode ? model_table(code) : model_interp(code, rs);
        v_d2 = v_d1; e_d2 = e_d1; t_d2 = t_d1; m_d2 = m_d1; c_d2 = c_d1;
        v_d1 = v;    e_d1 = expv; t_d1 = tag;  m_d1 = mono_on; c_d1 = code;
        in_valid      = v;
        in_mode       = mode;
        in_rise_shift = 3'(rs);
        in_code       = 10'(code);
    endtask

    function automatic string pick_tag(bit mode, int rs, int code);
        if (code % 64 == 0) return "R6";
        if (code == 1023)   return "R7";
        if (mode)           return "R5";
        if (rs > 6)         return "R4";
        return "R3";
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        in_valid = 1'b0;
        in_mode = 1'b0;
        in_rise_shift = 3'd3;
        in_code = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        report(out_valid == 1'b0, "R1", int'(out_valid), 0, "reset valid");
        report(out_result == 16'd0, "R1", int'(out_result), 0, "reset result");

        // Full sweep over both modes, every shift split and every code
        mono_on = 1;
        for (int m = 0; m < 2; m++) begin
            for (int rs = 0; rs < 8; rs++) begin
                if (m == 1 && rs > 0) continue;
                for (int c = 0; c < 1024; c++) begin
                    step(1'b1, m[0], rs, c, pick_tag(m[0], rs, c));
                end
                // gap so the next sweep's first code is not compared with this one
                step(1'b0, 1'b0, 0, 0, "R8");
                step(1'b0, 1'b0, 0, 0, "R8");
            end
        end
        mono_on = 0;

        // R9: configuration changes on every cycle, with idle gaps for R8
        for (int i = 0; i < 512; i++) begin
            if (i % 7 == 3) step(1'b0, ~i[0], 7 - (i % 8), (i * 91) % 1024, "R9");
            else            step(1'b1, i[0], (i / 2) % 8, (i * 37 + 11) % 1024, "R9");
        end

        // R7: largest code at each extreme, R4 clamp explicitly
        step(1'b1, 1'b0, 6, 1023, "R7");
        step(1'b1, 1'b0, 7, 1023, "R4");
        step(1'b1, 1'b1, 0, 1023, "R7");
        step(1'b1, 1'b0, 0, 0, "R6");
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 0, 0, "R8");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule